// File: doc/BRIEF.md
# Constant-Linear-Velocity Spindle Phase Servo

This block keeps a disc spinning at constant linear velocity by locking the frame rate recovered from the playback clock to a frame rate derived from the crystal reference. A counter divides reference-clock ticks into reference frames. Each recovered frame strobe that is qualified by sync-valid records its position within the current reference frame as a signed phase error in reference-clock counts. The error is saturated to the width of the error port.

Once per reference frame, the block turns the latest phase error into a three-state spindle command. The command is accelerate (driven high), decelerate (driven low) or release (output enable low, so the pin floats). A programmable deadband releases the motor when the error is small. The servo also releases the motor while it is disabled, and when no qualified recovered frame has arrived for a set number of reference frames. The pad's tri-state buffer is built from the level output and the enable output.

Top module: `clv_spindle_servo`

## Requirements
- R1: During and straight after reset the drive enable is 0, the phase error reads 0, and the block counts as having lost the recovered frames.
- R2: The reference counter advances only on cycles with `ref_tick` high. A reference frame ends on the tick that takes the count from DIV-1 back to 0. Cycles without a tick move neither the count nor the outputs.
- R3: A qualified strobe seen while the count is p records an error of +p when p < DIV/2, and p-DIV otherwise. A positive value means the recovered frame is late. The recorded error appears on `phase_err` in the cycle after the frame-ending tick.
- R4: The recorded error saturates at 2^(ERR_W-1)-1 and at -2^(ERR_W-1).
- R5: At a frame end, an error above the deadband gives accelerate: `spin_drive_oe`=1 and `spin_drive`=1.
- R6: At a frame end, an error below minus the deadband gives decelerate: `spin_drive_oe`=1 and `spin_drive`=0.
- R7: At a frame end, an error whose magnitude is at most `deadband` releases the motor (`spin_drive_oe`=0). The bound is inclusive.
- R8: A `frame_strobe` with `sync_ok` low is ignored. It changes neither the error nor the lost-frame count.
- R9: The cycle after `servo_en` is sampled low, the drive is released. It stays released at every frame end while `servo_en` is low.
- R10: Each frame without a qualified strobe adds one to a miss count, up to LOSS_FRAMES. Until the count reaches that limit, the last error keeps driving the decision. At the limit the drive is released. A frame with a qualified strobe clears the count.
- R11: The drive outputs and `phase_err` change only in the cycle that follows a frame-ending tick, except for the release on disable (R9).
- R12: If several qualified strobes fall in one reference frame, the last one sets the error used at that frame's end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable per crystal reference-clock count |
| frame_strobe | input | 1 | Recovered frame timing pulse |
| sync_ok | input | 1 | Qualifies `frame_strobe` as a valid recovered frame |
| servo_en | input | 1 | Servo enable; low releases the drive |
| deadband | input | ERR_W-1 | Error magnitude, in reference counts, that still counts as locked |
| spin_drive | output | 1 | Drive level: 1 accelerate, 0 decelerate |
| spin_drive_oe | output | 1 | Drive enable: 0 leaves the spindle pin floating |
| phase_err | output | ERR_W | Signed phase error latched at the last frame end |

## Verification
The bench builds the block with DIV=40, ERR_W=5 and LOSS_FRAMES=8. Frames are then only 40 reference ticks long, so dozens of frames, the full lost-frame window and the recovery after it fit in a short run. The 5-bit error range of -16..15 is narrower than half a frame. Positions 16..24 therefore reach both saturation limits, which can never happen at the default widths, where half a frame (1176) fits in 12 bits. Random tick gaps, strobe positions, sync qualification, deadband and enable changes run alongside directed frames at the half-frame split and at the edges of the deadband.

// File: rtl/clv_pkg.sv
package clv_pkg;

    typedef enum logic [1:0] {
        DRV_IDLE  = 2'd0,
        DRV_ACCEL = 2'd1,
        DRV_DECEL = 2'd2
    } drive_e;

endpackage

// File: rtl/clv_ref_divider.sv
module clv_ref_divider #(
    parameter int DIV   = 2352,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    output logic [CNT_W-1:0] pos,
    output logic             frame_end
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ref_tick) begin
            if (s_q.cnt == LAST) begin
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pos       = s_q.cnt;
    assign frame_end = ref_tick && (s_q.cnt == LAST);

    // R2: count never leaves its frame range
    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= LAST);

    // R2: no tick, no movement
    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ref_tick) |-> $stable(s_q.cnt));

endmodule

// File: rtl/clv_phase_meter.sv
module clv_phase_meter #(
    parameter int DIV   = 2352,
    parameter int CNT_W = 12,
    parameter int ERR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        pos,
    input  logic                    frame_end,
    input  logic                    frame_strobe,
    input  logic                    sync_ok,
    output logic signed [ERR_W-1:0] err_cur,
    output logic                    seen_cur
);

    localparam int HALF  = DIV / 2;
    localparam int MAX_E = (1 << (ERR_W - 1)) - 1;
    localparam int MIN_E = -(1 << (ERR_W - 1));

    typedef struct packed {
        logic signed [ERR_W-1:0] hold;
        logic                    seen;
    } meter_state_t;

    meter_state_t s_d, s_q;

    logic                    strobe_v;
    logic signed [ERR_W-1:0] meas;

    assign strobe_v = frame_strobe & sync_ok;

    // Signed distance from the reference frame start, wrapped at half a frame
    always_comb begin
        int raw;
        if (int'(pos) < HALF) begin
            raw = int'(pos);
        end else begin
            raw = int'(pos) - DIV;
        end
        if (raw > MAX_E) begin
            raw = MAX_E;
        end else if (raw < MIN_E) begin
            raw = MIN_E;
        end
        meas = ERR_W'(raw);
    end

    assign err_cur  = strobe_v ? meas : s_q.hold;
    assign seen_cur = s_q.seen | strobe_v;

    always_comb begin
        s_d      = s_q;
        s_d.hold = err_cur;
        s_d.seen = frame_end ? 1'b0 : seen_cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R8: unqualified strobes never touch the held error
    p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sync_ok) |-> $stable(s_q.hold));

    // R12: each reference frame starts with no strobe recorded
    p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_end) |-> !s_q.seen);

endmodule

// File: rtl/clv_drive_decider.sv
module clv_drive_decider
    import clv_pkg::*;
#(
    parameter int ERR_W       = 12,
    parameter int LOSS_FRAMES = 8,
    parameter int MISS_W      = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_end,
    input  logic                    seen_cur,
    input  logic signed [ERR_W-1:0] err_cur,
    input  logic                    servo_en,
    input  logic [ERR_W-2:0]        deadband,
    output drive_e                  cmd,
    output logic signed [ERR_W-1:0] phase_err
);

    localparam logic [MISS_W-1:0] LOSS_V = MISS_W'(LOSS_FRAMES);

    typedef struct packed {
        logic [MISS_W-1:0]       miss;
        drive_e                  cmd;
        logic signed [ERR_W-1:0] err;
    } dec_state_t;

    dec_state_t s_d, s_q;

    always_comb begin
        int mag;
        s_d = s_q;
        mag = int'(err_cur);
        if (mag < 0) begin
            mag = -mag;
        end
        if (frame_end) begin
            if (seen_cur) begin
                s_d.miss = '0;
                s_d.err  = err_cur;
            end else if (s_q.miss != LOSS_V) begin
                s_d.miss = s_q.miss + 1'b1;
            end
            if (!servo_en || (s_d.miss == LOSS_V)) begin
                s_d.cmd = DRV_IDLE;
            end else if (mag <= int'(deadband)) begin
                s_d.cmd = DRV_IDLE;
            end else if (int'(err_cur) > 0) begin
                s_d.cmd = DRV_ACCEL;
            end else begin
                s_d.cmd = DRV_DECEL;
            end
        end else if (!servo_en) begin
            s_d.cmd = DRV_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.miss <= LOSS_V;
            s_q.cmd  <= DRV_IDLE;
            s_q.err  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd       = s_q.cmd;
    assign phase_err = s_q.err;

    // R5: accelerate only on a late recovered frame
    p_accel_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cmd == DRV_ACCEL) |-> (s_q.err > 0));

    // R6: decelerate only on an early recovered frame
    p_decel_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cmd == DRV_DECEL) |-> (s_q.err < 0));

    // R9: a disabled servo releases the motor on the next cycle
    p_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(servo_en) |-> (s_q.cmd == DRV_IDLE));

    // R10: lost recovered frames keep the motor released
    p_lost_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.miss == LOSS_V) |-> (s_q.cmd == DRV_IDLE));

    // R11: the reported error only moves after a frame end
    p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_end) |-> $stable(s_q.err));

    // R11: an active command only moves after a frame end or a disable
    p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(frame_end) && $past(servo_en)) |-> $stable(s_q.cmd));

endmodule

// File: rtl/clv_spindle_servo.sv
module clv_spindle_servo
    import clv_pkg::*;
#(
    parameter int DIV         = 2352,
    parameter int ERR_W       = 12,
    parameter int LOSS_FRAMES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             frame_strobe,
    input  logic             sync_ok,
    input  logic             servo_en,
    input  logic [ERR_W-2:0] deadband,
    output logic             spin_drive,
    output logic             spin_drive_oe,
    output logic [ERR_W-1:0] phase_err
);

    localparam int CNT_W  = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int MISS_W = $clog2(LOSS_FRAMES + 1);

    logic [CNT_W-1:0]        pos;
    logic                    frame_end;
    logic signed [ERR_W-1:0] err_cur;
    logic                    seen_cur;
    drive_e                  cmd;
    logic signed [ERR_W-1:0] err_q;

    clv_ref_divider #(
        .DIV   (DIV),
        .CNT_W (CNT_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .pos       (pos),
        .frame_end (frame_end)
    );

    clv_phase_meter #(
        .DIV   (DIV),
        .CNT_W (CNT_W),
        .ERR_W (ERR_W)
    ) u_meter (
        .clk          (clk),
        .rst_n        (rst_n),
        .pos          (pos),
        .frame_end    (frame_end),
        .frame_strobe (frame_strobe),
        .sync_ok      (sync_ok),
        .err_cur      (err_cur),
        .seen_cur     (seen_cur)
    );

    clv_drive_decider #(
        .ERR_W       (ERR_W),
        .LOSS_FRAMES (LOSS_FRAMES),
        .MISS_W      (MISS_W)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .seen_cur  (seen_cur),
        .err_cur   (err_cur),
        .servo_en  (servo_en),
        .deadband  (deadband),
        .cmd       (cmd),
        .phase_err (err_q)
    );

    assign spin_drive    = (cmd == DRV_ACCEL);
    assign spin_drive_oe = (cmd != DRV_IDLE);
    assign phase_err     = err_q;

    // R1: a level is only meaningful while the drive is enabled
    p_level_oe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spin_drive |-> spin_drive_oe);

endmodule

// File: tb/clv_spindle_servo_tb.sv
module clv_spindle_servo_tb;

    localparam int DIV   = 40;
    localparam int ERR_W = 5;
    localparam int LOSS  = 8;
    localparam int HALF  = DIV / 2;
    localparam int MAXE  = (1 << (ERR_W - 1)) - 1;
    localparam int MINE  = -(1 << (ERR_W - 1));

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_tick = 1'b0;
    logic             frame_strobe = 1'b0;
    logic             sync_ok = 1'b0;
    logic             servo_en = 1'b0;
    logic [ERR_W-2:0] deadband = '0;
    logic             spin_drive;
    logic             spin_drive_oe;
    logic [ERR_W-1:0] phase_err;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // bench model state
    int m_cnt, m_hold, m_err, m_miss, m_cmd; // m_cmd: 0 release, 1 accel, 2 decel
    bit m_seen;

    always #5 clk = ~clk;

    clv_spindle_servo #(
        .DIV         (DIV),
        .ERR_W       (ERR_W),
        .LOSS_FRAMES (LOSS)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ref_tick      (ref_tick),
        .frame_strobe  (frame_strobe),
        .sync_ok       (sync_ok),
        .servo_en      (servo_en),
        .deadband      (deadband),
        .spin_drive    (spin_drive),
        .spin_drive_oe (spin_drive_oe),
        .phase_err     (phase_err)
    );

    function automatic int sat_err(int p);
        int v;
        v = (p < HALF) ? p : p - DIV;
        if (v > MAXE) v = MAXE;
        if (v < MINE) v = MINE;
        return v;
    endfunction

    function automatic int decide(int e, int db, bit en, int miss);
        int a;
        a = (e < 0) ? -e : e;
        if (!en || miss >= LOSS) return 0;
        if (a <= db) return 0;
        return (e > 0) ? 1 : 2;
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_hold = 0; m_err = 0; m_miss = LOSS; m_cmd = 0; m_seen = 0;
    endtask

    task automatic model_step(bit tk, bit st, bit sy);
        bit fe;
        fe = tk && (m_cnt == DIV - 1);
        if (st && sy) begin
            m_hold = sat_err(m_cnt);
            m_seen = 1'b1;
        end
        if (fe) begin
            if (m_seen) begin
                m_miss = 0;
                m_err  = m_hold;
            end else if (m_miss < LOSS) begin
                m_miss = m_miss + 1;
            end
            m_cmd  = decide(m_hold, int'(deadband), servo_en, m_miss);
            m_seen = 1'b0;
        end else if (!servo_en) begin
            m_cmd = 0;
        end
        if (tk) m_cnt = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(tag, int'(spin_drive_oe), (m_cmd != 0) ? 1 : 0);
        if (m_cmd != 0) chk(tag, int'(spin_drive), (m_cmd == 1) ? 1 : 0);
        chk(tag, int'($signed(phase_err)), m_err);
    endtask

    task automatic cyc(bit tk, bit st, bit sy);
        ref_tick     = tk;
        frame_strobe = st;
        sync_ok      = sy;
        model_step(tk, st, sy);
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic align();
        while (m_cnt != 0) cyc(1'b1, 1'b0, 1'b0);
    endtask

    // one full reference frame, ticking every cycle, strobes at p1 and p2
    task automatic frame(int p1, int p2, bit sy);
        for (int i = 0; i < DIV; i++) cyc(1'b1, (i == p1) || (i == p2), sy);
    endtask

    initial begin
        #(10 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1", int'(spin_drive_oe), 0);
        chk("R1", int'(phase_err), 0);
        rst_n = 1'b1;
        servo_en = 1'b1;
        deadband = 4'd2;
        cyc(1'b0, 1'b0, 1'b0);

        // R10: after reset the block starts lost, an empty frame keeps the release
        tag = "R10";
        frame(-1, -1, 1'b1);
        chk("R10", int'(spin_drive_oe), 0);

        // R3 R5: late recovered frame
        tag = "R5";
        frame(5, -1, 1'b1);
        chk("R3", int'($signed(phase_err)), 5);
        chk("R5", int'(spin_drive_oe), 1);
        chk("R5", int'(spin_drive), 1);

        // R6: early recovered frame
        tag = "R6";
        frame(30, -1, 1'b1);
        chk("R6", int'($signed(phase_err)), -10);
        chk("R6", int'(spin_drive_oe), 1);
        chk("R6", int'(spin_drive), 0);

        // R4: saturation on both sides of the half-frame split
        tag = "R4";
        frame(19, -1, 1'b1);
        chk("R4", int'($signed(phase_err)), 15);
        frame(20, -1, 1'b1);
        chk("R4", int'($signed(phase_err)), -16);
        frame(39, -1, 1'b1);
        chk("R3", int'($signed(phase_err)), -1);
        chk("R7", int'(spin_drive_oe), 0);

        // R7: inclusive deadband edge
        tag = "R7";
        deadband = 4'd3;
        frame(3, -1, 1'b1);
        chk("R7", int'(spin_drive_oe), 0);
        deadband = 4'd2;
        frame(3, -1, 1'b1);
        chk("R7", int'(spin_drive_oe), 1);
        chk("R7", int'(spin_drive), 1);

        // R8: unqualified strobe ignored
        tag = "R8";
        frame(10, -1, 1'b0);
        chk("R8", int'($signed(phase_err)), 3);
        chk("R8", int'(spin_drive), 1);

        // R12: last qualified strobe in a frame wins
        tag = "R12";
        frame(3, 30, 1'b1);
        chk("R12", int'($signed(phase_err)), -10);
        chk("R12", int'(spin_drive_oe), 1);

        // R10: loss window
        tag = "R10";
        for (int f = 0; f < LOSS - 1; f++) frame(-1, -1, 1'b1);
        chk("R10", int'(spin_drive_oe), 1);
        frame(-1, -1, 1'b1);
        chk("R10", int'(spin_drive_oe), 0);
        frame(8, -1, 1'b1);
        chk("R10", int'(spin_drive_oe), 1);

        // R9: disable mid-frame
        tag = "R9";
        repeat (7) cyc(1'b1, 1'b0, 1'b0);
        servo_en = 1'b0;
        cyc(1'b1, 1'b0, 1'b0);
        chk("R9", int'(spin_drive_oe), 0);
        align();
        frame(8, -1, 1'b1);
        chk("R9", int'(spin_drive_oe), 0);
        servo_en = 1'b1;
        frame(8, -1, 1'b1);
        chk("R9", int'(spin_drive_oe), 1);

        // R2: sparse ticks, strobe at count 6
        tag = "R2";
        for (int k = 0; k < 2 * DIV; k++) begin
            bit tk;
            tk = (k % 2) == 1;
            cyc(tk, m_cnt == 6 && tk, 1'b1);
        end
        chk("R2", int'($signed(phase_err)), 6);

        // R11 with random traffic, checked every cycle against the model
        tag = "R11";
        for (int n = 0; n < 4000; n++) begin
            if (n % 250 == 0) begin
                deadband = 4'($urandom_range(0, 15));
                servo_en = ($urandom_range(0, 4) != 0);
            end
            cyc(($urandom_range(0, 3) != 0), ($urandom_range(0, 39) == 0),
                ($urandom_range(0, 4) != 0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule